// File: doc/BRIEF.md
# Serial Data Byte Receiver

This block receives a compressed audio bitstream from an external host that owns the bit clock. It turns the serial bits into bytes and hands each byte to a downstream stream buffer with a one-cycle valid strobe. The serial clock, data, select and sync lines are asynchronous to the block. They pass through a synchroniser into the system clock domain. The system clock must run at least six times faster than the serial clock.

Three framing schemes are available. In select framing, a low select line brackets the bytes. In pulse framing, a sync line marks the first bit of a byte, and a byte chains straight into the next one while sync stays high. In gated framing, bits count only while sync is high. Separate controls choose the bit order and the active sampling edge. The mode inputs are expected to stay static while a transfer is in progress.

Top module: `sdi_byte_rx`

## Requirements
- R1: After reset, `byteValid` is 0 and `byteOut` is all zeros.
- R2: With `frameSel` equal to 0 or 3 (select framing), every group of 8 sampled bits taken while the select is active becomes one byte. Several bytes may follow one another inside a single select window.
- R3: With `lsbFirst`=0, the first sampled bit of a byte lands in bit 7 of `byteOut`. With `lsbFirst`=1, it lands in bit 0.
- R4: With `fallEdge`=0, bits are sampled on rising edges of `serClk`. With `fallEdge`=1, they are sampled on falling edges.
- R5: In select framing, a high select clears any partial byte. Those bits are never delivered, and the next byte starts fresh.
- R6: With `shareSel`=1, the select is the inverse of `ctrlSelN` and `dataSelN` has no effect. With `shareSel`=0, `dataSelN` is the select.
- R7: With `frameSel`=1 (pulse framing), sampling edges are ignored while the receiver is idle and sync is low. The first sampling edge with sync high supplies bit 0 of a byte.
- R8: In pulse framing, if sync is high on the eighth bit of a byte, the next 8 bits form another byte with no new sync. If sync is low on that bit, the receiver returns to idle.
- R9: With `frameSel`=2 (gated framing), sampling edges taken while sync is low carry no bit and do not advance the byte.
- R10: In gated framing, a rising edge of sync restarts the bit count and discards any partial byte.
- R11: Each completed byte gives exactly one `byteValid` pulse of one cycle. `byteOut` holds that byte until the next one completes. No pulse appears without a completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSel | input | 2 | Framing: 0/3 select, 1 pulse, 2 gated |
| lsbFirst | input | 1 | 1 = least significant bit first |
| fallEdge | input | 1 | 1 = sample on falling serial clock edge |
| shareSel | input | 1 | 1 = derive data select from inverted control select |
| serClk | input | 1 | Serial bit clock from host |
| serData | input | 1 | Serial data |
| dataSelN | input | 1 | Active-low data select |
| ctrlSelN | input | 1 | Active-low control select |
| syncIn | input | 1 | Byte sync for pulse and gated framing |
| byteOut | output | BYTE_W | Last completed byte |
| byteValid | output | 1 | One-cycle strobe per completed byte |

## Verification
Select framing is driven with back-to-back bytes in one window, which distinguishes true byte chaining from per-window framing. Each bit order is tried, along with the falling sampling edge, and the asymmetric byte values expose any reversed or shifted assembly. Aborted partial bytes, and sync gaps in gated framing, show whether stale bits leak into the next byte. Pulse-framing streams compare a byte that chains with sync held high on the eighth bit against one that goes idle. Idle edges are sent before and after each stream to show that they are ignored.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;
  typedef enum logic [1:0] {
    FRM_SELECT = 2'd0,
    FRM_PULSE  = 2'd1,
    FRM_GATED  = 2'd2,
    FRM_ALT    = 2'd3
  } frameMode_e;

  typedef struct packed {
    logic shiftEn;
    logic bitVal;
    logic lastBit;
  } rxStrobe_t;
endpackage

// File: rtl/sdi_rx_ctrl.sv
module sdi_rx_ctrl
  import sdi_rx_pkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int BYTE_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] frameSel,
  input  logic       fallEdge,
  input  logic       shareSel,
  input  logic       serClk,
  input  logic       serData,
  input  logic       dataSelN,
  input  logic       ctrlSelN,
  input  logic       syncIn,
  output rxStrobe_t  strb,
  output logic       selActive,
  output logic       syncLvl
);
  localparam int NIN = 5;
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam logic [NIN-1:0] RST_VAL = 5'b01100;

  logic [NIN-1:0] stage [SYNC_DEPTH];
  logic [NIN-1:0] rawIn, syncd;
  logic sClk, sDat, sDsel, sCsel, sSync;
  logic clkPrev, syncPrev;
  logic sampleEdge, syncRise;
  logic [CNT_W-1:0] cnt, cntNext, cntBase;
  logic busy, busyNext;
  frameMode_e mode;

  assign rawIn = {syncIn, ctrlSelN, dataSelN, serData, serClk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_DEPTH; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= rawIn;
      for (int i = 1; i < SYNC_DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncd = stage[SYNC_DEPTH-1];
  assign {sSync, sCsel, sDsel, sDat, sClk} = syncd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      syncPrev <= 1'b0;
      cnt      <= '0;
      busy     <= 1'b0;
    end else begin
      clkPrev  <= sClk;
      syncPrev <= sSync;
      cnt      <= cntNext;
      busy     <= busyNext;
    end
  end

  assign sampleEdge = fallEdge ? (clkPrev & ~sClk) : (~clkPrev & sClk);
  assign syncRise   = sSync & ~syncPrev;
  assign selActive  = shareSel ? ~sCsel : ~sDsel;
  assign syncLvl    = sSync;
  assign mode       = frameMode_e'(frameSel);
  assign cntBase    = syncRise ? '0 : cnt;

  always_comb begin
    strb         = '0;
    strb.bitVal  = sDat;
    cntNext      = cnt;
    busyNext     = 1'b0;
    case (mode)
      FRM_PULSE: begin
        busyNext = busy;
        if (sampleEdge && (busy || sSync)) begin
          strb.shiftEn = 1'b1;
          if (cnt == LAST) begin
            strb.lastBit = 1'b1;
            cntNext      = '0;
            busyNext     = sSync;
          end else begin
            cntNext  = cnt + 1'b1;
            busyNext = 1'b1;
          end
        end
      end
      FRM_GATED: begin
        cntNext = cntBase;
        if (sampleEdge && sSync) begin
          strb.shiftEn = 1'b1;
          if (cntBase == LAST) begin
            strb.lastBit = 1'b1;
            cntNext      = '0;
          end else begin
            cntNext = cntBase + 1'b1;
          end
        end
      end
      default: begin
        if (!selActive) begin
          cntNext = '0;
        end else if (sampleEdge) begin
          strb.shiftEn = 1'b1;
          if (cnt == LAST) begin
            strb.lastBit = 1'b1;
            cntNext      = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/sdi_rx_dp.sv
module sdi_rx_dp
  import sdi_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lsbFirst,
  input  rxStrobe_t         strb,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid
);
  logic [BYTE_W-1:0] shReg, nextSh;

  assign nextSh = lsbFirst ? {strb.bitVal, shReg[BYTE_W-1:1]}
                           : {shReg[BYTE_W-2:0], strb.bitVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      byteOut   <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= strb.shiftEn & strb.lastBit;
      if (strb.shiftEn) shReg <= nextSh;
      if (strb.shiftEn && strb.lastBit) byteOut <= nextSh;
    end
  end

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R11
  valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteValid) |-> $past(strb.shiftEn));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> $stable(byteOut));
endmodule

// File: rtl/sdi_byte_rx.sv
module sdi_byte_rx
  import sdi_rx_pkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        frameSel,
  input  logic              lsbFirst,
  input  logic              fallEdge,
  input  logic              shareSel,
  input  logic              serClk,
  input  logic              serData,
  input  logic              dataSelN,
  input  logic              ctrlSelN,
  input  logic              syncIn,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid
);
  rxStrobe_t strb;
  logic selActive, syncLvl;

  sdi_rx_ctrl #(.SYNC_DEPTH(SYNC_DEPTH), .BYTE_W(BYTE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameSel(frameSel), .fallEdge(fallEdge),
    .shareSel(shareSel), .serClk(serClk), .serData(serData),
    .dataSelN(dataSelN), .ctrlSelN(ctrlSelN), .syncIn(syncIn),
    .strb(strb), .selActive(selActive), .syncLvl(syncLvl)
  );

  sdi_rx_dp #(.BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .lsbFirst(lsbFirst), .strb(strb),
    .byteOut(byteOut), .byteValid(byteValid)
  );

  // R5
  sel_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((frameSel == 2'd0 || frameSel == 2'd3) && !selActive) |=> !byteValid);

  // R9
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSel == 2'd2 && !syncLvl) |=> !byteValid);
endmodule

// File: tb/test_sdi_byte_rx.sv
module test_sdi_byte_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] frameSel = 2'd0;
  logic lsbFirst = 1'b0, fallEdge = 1'b0, shareSel = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, dataSelN = 1'b1, ctrlSelN = 1'b1, syncIn = 1'b0;
  logic [7:0] byteOut;
  logic byteValid;

  int checks = 0;
  int fails = 0;
  logic prevValid = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];
  string curTag = "R2";

  always #2.5 clk = ~clk;

  sdi_byte_rx i_sdi_byte_rx (
    .clk(clk), .rstN(rstN), .frameSel(frameSel), .lsbFirst(lsbFirst),
    .fallEdge(fallEdge), .shareSel(shareSel), .serClk(serClk),
    .serData(serData), .dataSelN(dataSelN), .ctrlSelN(ctrlSelN),
    .syncIn(syncIn), .byteOut(byteOut), .byteValid(byteValid)
  );

  // Reference: every delivered byte is popped from the expected stream.
  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        checks++;
        if (prevValid) begin
          fails++;
          $display("FAIL R11: valid held two cycles, actual=1 expected=0");
        end
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected byte actual=%02h expected=none", curTag, byteOut);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (byteOut !== e) begin
            fails++;
            $display("FAIL %s: byte actual=%02h expected=%02h", t, byteOut, e);
          end
        end
      end
      prevValid <= byteValid;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input logic s);
    serData = b;
    syncIn  = s;
    waitCyc(4);
    serClk = ~serClk;
    waitCyc(4);
    serClk = ~serClk;
  endtask

  task automatic sendByte(input logic [7:0] v, input logic sFirst,
                          input logic sMid, input logic sLast);
    for (int i = 0; i < 8; i++) begin
      logic b, s;
      b = lsbFirst ? v[i] : v[7-i];
      s = (i == 0) ? sFirst : ((i == 7) ? sLast : sMid);
      sendBit(b, s);
    end
  endtask

  task automatic expectByte(input logic [7:0] v, input string t);
    expQ.push_back(v);
    tagQ.push_back(t);
  endtask

  task automatic settle();
    waitCyc(20);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL %s: missing bytes actual=0 expected=%0d", curTag, expQ.size());
      expQ.delete();
      tagQ.delete();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    waitCyc(4);
    // R1 reset state
    checks++;
    if (byteValid !== 1'b0 || byteOut !== 8'h00) begin
      fails++;
      $display("FAIL R1: reset actual=%b/%02h expected=0/00", byteValid, byteOut);
    end
    rstN = 1'b1;
    waitCyc(6);

    // R2, R3: MSb first, two bytes in one select window
    curTag = "R2";
    dataSelN = 1'b0; waitCyc(6);
    expectByte(8'hA5, "R2"); sendByte(8'hA5, 0, 0, 0);
    expectByte(8'h3C, "R3"); sendByte(8'h3C, 0, 0, 0);
    dataSelN = 1'b1; settle();

    // R3: LSb first
    curTag = "R3";
    lsbFirst = 1'b1; dataSelN = 1'b0; waitCyc(6);
    expectByte(8'h1E, "R3"); sendByte(8'h1E, 0, 0, 0);
    dataSelN = 1'b1; settle();
    lsbFirst = 1'b0;

    // R4: falling-edge sampling
    curTag = "R4";
    fallEdge = 1'b1; serClk = 1'b1; waitCyc(10);
    dataSelN = 1'b0; waitCyc(6);
    expectByte(8'hC3, "R4"); sendByte(8'hC3, 0, 0, 0);
    dataSelN = 1'b1; settle();
    fallEdge = 1'b0; serClk = 1'b0; waitCyc(10);

    // R5: abort of partial byte
    curTag = "R5";
    dataSelN = 1'b0; waitCyc(6);
    sendBit(1, 0); sendBit(0, 0); sendBit(1, 0);
    dataSelN = 1'b1; waitCyc(10);
    dataSelN = 1'b0; waitCyc(6);
    expectByte(8'h5A, "R5"); sendByte(8'h5A, 0, 0, 0);
    dataSelN = 1'b1; settle();

    // R6: shared select
    curTag = "R6";
    shareSel = 1'b1; ctrlSelN = 1'b0; waitCyc(6);
    expectByte(8'h96, "R6"); sendByte(8'h96, 0, 0, 0);
    ctrlSelN = 1'b1; waitCyc(6);
    dataSelN = 1'b0; waitCyc(6);
    sendByte(8'hFF, 0, 0, 0);
    dataSelN = 1'b1; settle();
    shareSel = 1'b0; waitCyc(6);

    // R7, R8: pulse framing
    curTag = "R7";
    frameSel = 2'd1; waitCyc(6);
    sendBit(1, 0); sendBit(1, 0);
    expectByte(8'h47, "R7"); sendByte(8'h47, 1, 0, 0);
    curTag = "R8";
    expectByte(8'h12, "R8"); sendByte(8'h12, 1, 0, 1);
    expectByte(8'h34, "R8"); sendByte(8'h34, 0, 0, 0);
    sendBit(1, 0); sendBit(0, 0); sendBit(1, 0);
    expectByte(8'hE7, "R8"); sendByte(8'hE7, 1, 0, 0);
    syncIn = 1'b0; settle();

    // R9, R10: gated framing
    curTag = "R10";
    frameSel = 2'd2; waitCyc(6);
    sendBit(1, 1); sendBit(1, 1); sendBit(1, 1);
    sendBit(1, 0); sendBit(1, 0);
    expectByte(8'h6B, "R10"); sendByte(8'h6B, 1, 1, 1);
    curTag = "R9";
    expectByte(8'hD2, "R9"); sendByte(8'hD2, 1, 1, 1);
    expectByte(8'h0F, "R9"); sendByte(8'h0F, 1, 1, 1);
    sendByte(8'hAA, 0, 0, 0);
    syncIn = 1'b0; settle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule